// File: doc/BRIEF.md
# Control OUT Endpoint Zero Handshake Register

This block holds the software-visible control word for the default control OUT endpoint of a USB device. It also chooses the handshake returned for every received packet. Software reads and writes a single 32-bit word through a plain write-strobe port, and the read value is always present. The USB core logic feeds it single-cycle event strobes: SETUP token seen, SETUP data packet received, OUT data packet received, OUT transfer completed and SETUP phase done. It also feeds a level for the global OUT NAK condition.

The enable, NAK and STALL state is shared between software and hardware, and each has defined set and clear events. For every packet strobe the block issues one handshake code one cycle later. STALL outranks NAK, and NAK outranks ACK. A SETUP data packet is always acknowledged. Completion events clear the enable bit one cycle before the matching interrupt strobe, and the snoop bit is sent to the datapath.

Top module: `ep0_out_ctrl`

## Requirements
- R1: After reset the read word is 0, hs_valid is 0 and both interrupt strobes are 0.
- R2: The read word shows enable at bit 31, STALL at bit 21, snoop at bit 20 and the internal NAK state at bit 17. Endpoint type bits 19:18 read 2'b00 (control). Bits 30, 29:28, 27, 26, 25:22 and 16:0 read 0. Writing bit 30 (disable) has no effect.
- R3: Writing 1 to bit 31 sets enable, and writing 0 leaves it unchanged. A setup_done or xfer_done strobe clears enable at that clock edge, and this beats a coincident write. The matching interrupt (irq_setup_done or irq_xfer_done) pulses for one cycle, one cycle after enable reads 0.
- R4: Writing 1 to bit 27 sets the NAK state, and writing 1 to bit 26 clears it. If both are written together, the NAK state is set.
- R5: An xfer_done or setup_data strobe sets the NAK state. Either one beats a coincident clear-NAK write.
- R6: Bit 21 (STALL) takes the written value. A setup_token strobe clears it, and this beats a coincident write.
- R7: For an out_data strobe, the handshake in the next cycle is STALL if STALL is set. Otherwise it is NAK if the NAK state is set, global_out_nak is high or enable is clear. Otherwise it is ACK. All of these are judged on the values before that edge.
- R8: A setup_data strobe is answered with ACK in the next cycle, whatever the STALL, NAK, enable and global NAK values are.
- R9: Bit 20 (snoop) takes the written value and drives the snoop_en output.
- R10: hs_code encodes ACK=2'b01, NAK=2'b10 and STALL=2'b11. hs_valid is high for exactly one cycle per packet strobe, and hs_code is 2'b00 while hs_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value |
| setup_token | input | 1 | SETUP token received for this endpoint |
| setup_data | input | 1 | SETUP data packet received |
| out_data | input | 1 | OUT data packet received |
| xfer_done | input | 1 | OUT transfer completed |
| setup_done | input | 1 | SETUP phase done |
| global_out_nak | input | 1 | Global OUT NAK level |
| hs_valid | output | 1 | Handshake code valid |
| hs_code | output | 2 | Handshake: 01 ACK, 10 NAK, 11 STALL |
| irq_setup_done | output | 1 | SETUP phase done interrupt strobe |
| irq_xfer_done | output | 1 | Transfer completed interrupt strobe |
| snoop_en | output | 1 | Skip correctness check on OUT data |

## Verification
The properties assume that each event input is a single-cycle strobe. They also assume that setup_data and out_data never arrive in the same cycle, and that no packet strobe comes in the cycle right after another, so every handshake can be tied to one packet. The stimulus keeps to this: every event is raised for exactly one clock and then dropped. There is always at least one idle cycle between packets, which lets the scoreboard pair each handshake with its packet. Coincident cases (a write together with a hardware event) are driven on purpose, because the priority rules are defined for them.

// File: rtl/ep0_out_pkg.sv
package ep0_out_pkg;

   typedef enum logic [1:0] {
      HS_NONE  = 2'b00,
      HS_ACK   = 2'b01,
      HS_NAK   = 2'b10,
      HS_STALL = 2'b11
   } hs_e;

   // field positions shared by the register file and the checker
   localparam int POS_EN     = 31;
   localparam int POS_DIS    = 30;
   localparam int POS_SETNAK = 27;
   localparam int POS_CLRNAK = 26;
   localparam int POS_STALL  = 21;
   localparam int POS_SNOOP  = 20;
   localparam int POS_TYPE   = 18;
   localparam int POS_NAKST  = 17;
   localparam int MIN_REG_W  = 32;

   typedef struct packed {
      logic en;
      logic nak;
      logic stall;
      logic snoop;
   } ep_state_t;

endpackage

// File: rtl/ep0_out_csr.sv
module ep0_out_csr
   import ep0_out_pkg::*;
#(
   parameter int         REG_W   = 32,
   parameter logic [1:0] EP_TYPE = 2'b00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             setup_token,
   input  logic             setup_data,
   input  logic             xfer_done,
   input  logic             setup_done,
   output ep_state_t        state,
   output logic [REG_W-1:0] reg_rdata
);

   ep_state_t st_q, st_d;

   logic sw_set_nak, sw_clr_nak, hw_set_nak, hw_clr_en;

   assign sw_set_nak = reg_wr & reg_wdata[POS_SETNAK];
   assign sw_clr_nak = reg_wr & reg_wdata[POS_CLRNAK];
   assign hw_set_nak = xfer_done | setup_data;
   assign hw_clr_en  = xfer_done | setup_done;

   always_comb begin
      st_d = st_q;
      // enable: software may only set, completion events clear
      if (hw_clr_en)
         st_d.en = 1'b0;
      else if (reg_wr && reg_wdata[POS_EN])
         st_d.en = 1'b1;
      // NAK state: any set source wins over a clear
      if (sw_set_nak || hw_set_nak)
         st_d.nak = 1'b1;
      else if (sw_clr_nak)
         st_d.nak = 1'b0;
      // STALL: written value, SETUP token clears
      if (setup_token)
         st_d.stall = 1'b0;
      else if (reg_wr)
         st_d.stall = reg_wdata[POS_STALL];
      if (reg_wr)
         st_d.snoop = reg_wdata[POS_SNOOP];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         st_q <= '0;
      else
         st_q <= st_d;
   end

   always_comb begin
      reg_rdata                       = '0;
      reg_rdata[POS_EN]               = st_q.en;
      reg_rdata[POS_STALL]            = st_q.stall;
      reg_rdata[POS_SNOOP]            = st_q.snoop;
      reg_rdata[POS_TYPE+1:POS_TYPE]  = EP_TYPE;
      reg_rdata[POS_NAKST]            = st_q.nak;
   end

   assign state = st_q;

endmodule

// File: rtl/ep0_out_hs.sv
module ep0_out_hs
   import ep0_out_pkg::*;
#(
   parameter bit HS_REG = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  ep_state_t state,
   input  logic      global_out_nak,
   input  logic      setup_data,
   input  logic      out_data,
   output logic      hs_valid,
   output hs_e       hs_code
);

   hs_e  pick;
   logic pkt;

   assign pkt = setup_data | out_data;

   always_comb begin
      pick = HS_NONE;
      if (setup_data)
         pick = HS_ACK;
      else if (out_data) begin
         if (state.stall)
            pick = HS_STALL;
         else if (state.nak || global_out_nak || !state.en)
            pick = HS_NAK;
         else
            pick = HS_ACK;
      end
   end

   generate
      if (HS_REG) begin : g_reg
         logic v_q;
         hs_e  c_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               c_q <= HS_NONE;
            end else begin
               v_q <= pkt;
               c_q <= pick;
            end
         end
         assign hs_valid = v_q;
         assign hs_code  = c_q;
      end else begin : g_comb
         assign hs_valid = pkt;
         assign hs_code  = pick;
      end
   endgenerate

endmodule

// File: rtl/ep0_out_irq.sv
module ep0_out_irq #(
   parameter int N_EVT  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt,
   output logic [N_EVT-1:0] irq
);

   logic [STAGES-1:0][N_EVT-1:0] pipe;

   always_ff @(posedge clk) begin
      if (!rst_n)
         pipe[0] <= '0;
      else
         pipe[0] <= evt;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n)
               pipe[s] <= '0;
            else
               pipe[s] <= pipe[s-1];
         end
      end
   endgenerate

   assign irq = pipe[STAGES-1];

endmodule

// File: rtl/ep0_out_ctrl.sv
module ep0_out_ctrl
   import ep0_out_pkg::*;
#(
   parameter int REG_W      = 32,
   parameter bit HS_REG     = 1'b1,
   parameter int IRQ_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             setup_token,
   input  logic             setup_data,
   input  logic             out_data,
   input  logic             xfer_done,
   input  logic             setup_done,
   input  logic             global_out_nak,
   output logic             hs_valid,
   output logic [1:0]       hs_code,
   output logic             irq_setup_done,
   output logic             irq_xfer_done,
   output logic             snoop_en
);

   localparam int N_EVT = 2;

   generate
      if (REG_W < MIN_REG_W) begin : g_bad_w
         $error("REG_W must hold all control fields");
      end
      if (IRQ_STAGES < 2) begin : g_bad_stg
         $error("IRQ_STAGES must be at least 2 so enable clears first");
      end
   endgenerate

   ep_state_t        state;
   hs_e              code;
   logic [N_EVT-1:0] evt, irq;

   ep0_out_csr #(.REG_W(REG_W), .EP_TYPE(2'b00)) u_csr (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr      (reg_wr),
      .reg_wdata   (reg_wdata),
      .setup_token (setup_token),
      .setup_data  (setup_data),
      .xfer_done   (xfer_done),
      .setup_done  (setup_done),
      .state       (state),
      .reg_rdata   (reg_rdata)
   );

   ep0_out_hs #(.HS_REG(HS_REG)) u_hs (
      .clk            (clk),
      .rst_n          (rst_n),
      .state          (state),
      .global_out_nak (global_out_nak),
      .setup_data     (setup_data),
      .out_data       (out_data),
      .hs_valid       (hs_valid),
      .hs_code        (code)
   );

   assign evt = {xfer_done, setup_done};

   ep0_out_irq #(.N_EVT(N_EVT), .STAGES(IRQ_STAGES)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt),
      .irq   (irq)
   );

   assign hs_code        = code;
   assign irq_setup_done = irq[0];
   assign irq_xfer_done  = irq[1];
   assign snoop_en       = state.snoop;

endmodule

// File: rtl/ep0_out_ctrl_chk.sv
module ep0_out_ctrl_chk #(
   parameter int REG_W      = 32,
   parameter bit HS_REG     = 1'b1,
   parameter int IRQ_STAGES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [REG_W-1:0] reg_wdata,
   input logic [REG_W-1:0] reg_rdata,
   input logic             setup_token,
   input logic             setup_data,
   input logic             out_data,
   input logic             xfer_done,
   input logic             setup_done,
   input logic             hs_valid,
   input logic [1:0]       hs_code,
   input logic             irq_xfer_done,
   input logic             snoop_en
);

   AST_DIS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && reg_wdata[30] |=> !reg_rdata[30]);                           // R2

   AST_EN_BEFORE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      irq_xfer_done |-> !$past(reg_rdata[31]));                              // R3

   AST_SETNAK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && reg_wdata[27] |=> reg_rdata[17]);                            // R4

   AST_HW_NAK: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done || setup_data) |=> reg_rdata[17]);                          // R5

   AST_STALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      setup_token |=> !reg_rdata[21]);                                       // R6

   AST_SNOOP_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> snoop_en == $past(reg_wdata[20]));                          // R9

   AST_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !hs_valid |-> hs_code == 2'b00);                                       // R10

   generate
      if (HS_REG) begin : g_hs
         AST_STALL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            out_data && !setup_data && reg_rdata[21] |=> hs_code == 2'b11);  // R7

         AST_SETUP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
            setup_data |=> hs_valid && hs_code == 2'b01);                    // R8
      end
   endgenerate

endmodule

bind ep0_out_ctrl ep0_out_ctrl_chk #(
   .REG_W(REG_W), .HS_REG(HS_REG), .IRQ_STAGES(IRQ_STAGES)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_wr        (reg_wr),
   .reg_wdata     (reg_wdata),
   .reg_rdata     (reg_rdata),
   .setup_token   (setup_token),
   .setup_data    (setup_data),
   .out_data      (out_data),
   .xfer_done     (xfer_done),
   .setup_done    (setup_done),
   .hs_valid      (hs_valid),
   .hs_code       (hs_code),
   .irq_xfer_done (irq_xfer_done),
   .snoop_en      (snoop_en)
);

// File: tb/ep0_out_ctrl_test.sv
module ep0_out_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        setup_token = 1'b0, setup_data = 1'b0, out_data = 1'b0;
   logic        xfer_done = 1'b0, setup_done = 1'b0, global_out_nak = 1'b0;
   logic        hs_valid, irq_setup_done, irq_xfer_done, snoop_en;
   logic [1:0]  hs_code;

   int checks = 0;
   int fails  = 0;
   logic [1:0] expq[$];
   string      tagq[$];

   localparam logic [1:0] ACK = 2'b01, NAK = 2'b10, STL = 2'b11;

   always #10 clk = ~clk;

   ep0_out_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .setup_token(setup_token), .setup_data(setup_data),
      .out_data(out_data), .xfer_done(xfer_done), .setup_done(setup_done),
      .global_out_nak(global_out_nak), .hs_valid(hs_valid), .hs_code(hs_code),
      .irq_setup_done(irq_setup_done), .irq_xfer_done(irq_xfer_done),
      .snoop_en(snoop_en)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_rd(input logic [31:0] exp, input string req);
      check(reg_rdata === exp, req, reg_rdata, exp);
   endtask

   task automatic write(input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   // driver: raise a packet strobe and queue the expected handshake
   task automatic pkt(input bit is_setup, input logic [1:0] exp, input string req);
      @(negedge clk);
      expq.push_back(exp);
      tagq.push_back(req);
      if (is_setup) setup_data = 1'b1; else out_data = 1'b1;
      @(negedge clk);
      setup_data = 1'b0; out_data = 1'b0;
      @(negedge clk);
   endtask

   // monitor: compare every handshake with the head of the queue
   always @(negedge clk) begin
      if (rst_n && hs_valid) begin
         if (expq.size() == 0) begin
            check(1'b0, "R10 unexpected handshake", {30'd0, hs_code}, 32'd0);
         end else begin
            logic [1:0] e;
            string      t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check(hs_code === e, t, {30'd0, hs_code}, {30'd0, e});
         end
      end
   end

   initial begin
      #4_000_000;
      check(1'b0, "watchdog", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk_rd(32'h0, "R1 read word");
      check({hs_valid, hs_code, irq_setup_done, irq_xfer_done} === 5'b0, "R1 outputs",
            {27'd0, hs_valid, hs_code, irq_setup_done, irq_xfer_done}, 32'd0);

      // R2/R4: all ones: en, stall, snoop, set+clear NAK -> NAK set
      write(32'hFFFF_FFFF);
      chk_rd(32'h8032_0000, "R2 R4 layout and set-wins");
      check(snoop_en === 1'b1, "R9 snoop out", {31'd0, snoop_en}, 32'd1);

      // R7 STALL outranks NAK and global NAK
      global_out_nak = 1'b1;
      pkt(1'b0, STL, "R7 stall first");
      global_out_nak = 1'b0;

      // R6 SETUP token clears STALL
      @(negedge clk); setup_token = 1'b1;
      @(negedge clk); setup_token = 1'b0;
      chk_rd(32'h8012_0000, "R6 token clears stall");

      pkt(1'b0, NAK, "R7 nak state");

      // R4 clear NAK; enable kept, snoop off
      write(32'h8400_0000);
      chk_rd(32'h8000_0000, "R4 clear nak");
      check(snoop_en === 1'b0, "R9 snoop off", {31'd0, snoop_en}, 32'd0);
      pkt(1'b0, ACK, "R7 ack");
      global_out_nak = 1'b1;
      pkt(1'b0, NAK, "R7 global nak");
      global_out_nak = 1'b0;

      // R8 SETUP data always ACKed, and sets NAK (R5)
      write(32'h8020_0000);
      global_out_nak = 1'b1;
      pkt(1'b1, ACK, "R8 setup ack");
      global_out_nak = 1'b0;
      chk_rd(32'h8022_0000, "R5 nak after setup");

      // R3 writing 0 to enable has no effect
      write(32'h0400_0000);
      chk_rd(32'h8000_0000, "R3 en write zero");

      // R3/R5 transfer done: enable clears, NAK sets, irq one cycle later
      @(negedge clk); xfer_done = 1'b1;
      @(negedge clk); xfer_done = 1'b0;
      chk_rd(32'h0002_0000, "R3 R5 xfer done state");
      check(irq_xfer_done === 1'b0, "R3 irq not yet", {31'd0, irq_xfer_done}, 32'd0);
      @(negedge clk);
      check(irq_xfer_done === 1'b1, "R3 irq xfer", {31'd0, irq_xfer_done}, 32'd1);
      @(negedge clk);
      check(irq_xfer_done === 1'b0, "R3 irq single", {31'd0, irq_xfer_done}, 32'd0);

      // R7 enable clear gives NAK
      write(32'h0400_0000);
      chk_rd(32'h0, "R4 nak cleared");
      pkt(1'b0, NAK, "R7 disabled nak");

      // R3 setup_done beats coincident enable write
      @(negedge clk);
      reg_wr = 1'b1; reg_wdata = 32'h8000_0000; setup_done = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; setup_done = 1'b0;
      chk_rd(32'h0, "R3 hw clear wins");
      @(negedge clk);
      check(irq_setup_done === 1'b1, "R3 irq setup", {31'd0, irq_setup_done}, 32'd1);

      // R5 xfer_done beats clear-NAK write; R6 token beats stall write
      @(negedge clk);
      reg_wr = 1'b1; reg_wdata = 32'h0420_0000; xfer_done = 1'b1; setup_token = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; xfer_done = 1'b0; setup_token = 1'b0;
      chk_rd(32'h0002_0000, "R5 R6 coincident events");

      // R2 disable bit ignored
      write(32'h4010_0000);
      chk_rd(32'h0012_0000, "R2 disable ignored");
      check(snoop_en === 1'b1, "R9 snoop set", {31'd0, snoop_en}, 32'd1);

      repeat (3) @(negedge clk);
      check(expq.size() == 0, "R10 missing handshake", expq.size(), 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule